// File: doc/BRIEF.md
# Bit-Serial Weighted Dot Product Unit

This unit is the arithmetic core of a bit-serial integer matrix multiplier. Each integer operand is split into binary bit planes. A scheduler feeds the unit one pair of K-bit plane slices per cycle, one slice from each operand. The unit ANDs the two slices, which is a one-bit multiply at each position. It counts the ones in the AND result with a pipelined compressor tree. The count, negated when asked, is then added to a wide accumulator. Before that addition, the old accumulator value is cleared, kept as it is, or doubled.

Plane pairs (i, j) are issued in wavefronts of equal i+j, from the largest sum down to zero. Doubling the accumulator once at the start of each new wavefront therefore gives every contribution its weight 2^(i+j), and no variable shifter is needed. Negating the pairs where exactly one plane is a two's-complement sign plane extends the scheme to signed operands. A dot product longer than K elements takes several back-to-back cycles per plane pair. Only the first of those cycles carries the clear or double mode.

The control inputs are registered alongside the data, so each slice is combined under the settings that were issued with it. Any operand precision works, provided the accumulator does not overflow.

Top module: `bitserial_dpu`

## Requirements
- R1: While reset is held and right after it is released, `accOut` is 0 and `outValid` is low.
- R2: The contribution of a slice pair is the number of positions where both `lhsBits` and `rhsBits` are 1. Its value lies between 0 and VEC_W. This holds for every bit position, including the last group of three when VEC_W is not a multiple of three.
- R3: `accMode` is encoded as follows: 2'b00 keeps the old accumulator, 2'b01 clears it and 2'b10 doubles it. The reserved code 2'b11 behaves like 2'b00.
- R4: In clear mode, the new accumulator equals the slice's contribution alone.
- R5: When `negate` is 1, the contribution is subtracted instead of added (two's complement, ACC_W bits).
- R6: A cycle with `inValid` low never changes `accOut` and never raises `outValid`, whatever the other inputs carry.
- R7: In double mode, the new accumulator is twice the old value plus the contribution, modulo 2^ACC_W.
- R8: Each accepted slice produces exactly one `outValid` pulse, in issue order, under its own `negate` and `accMode` settings. The pulse comes 2+ceil(log2(ceil(VEC_W/3))) rising edges after the edge that samples the slice (6 for VEC_W=32). The unit accepts one slice per cycle with no gaps.
- R9: The wavefront schedule, with negation on the pairs where exactly one plane is a sign plane, leaves the exact dot product in the accumulator. This holds for unsigned and signed operands of any precision and for vectors of several slices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | A slice pair is presented this cycle |
| lhsBits | input | VEC_W | Bit-plane slice of the left operand |
| rhsBits | input | VEC_W | Bit-plane slice of the right operand |
| negate | input | 1 | Subtract this slice's contribution |
| accMode | input | 2 | 00 keep, 01 clear, 10 double, 11 keep |
| outValid | output | 1 | The accumulator was updated on the last edge |
| accOut | output | ACC_W | Accumulator value |

## Verification
The accumulator doubling at a wavefront start and the negation of a sign-plane pair can fall in the same cycle. The clear of a new dot product can also reach the accumulator in the cycle right after the last update of the previous dot product, while both are still in the pipeline. Both cases are provoked by streaming whole signed dot products back to back, with no idle cycle between them. The scoreboard judges the accumulator after every pulse against a model of the three modes. It also checks the final value of each dot product against an integer dot product computed directly from the random operands.

// File: rtl/bitserial_dpu_pkg.sv
package bitserial_dpu_pkg;

  typedef enum logic [1:0] {
    ACC_KEEP   = 2'b00,
    ACC_ZERO   = 2'b01,
    ACC_DOUBLE = 2'b10
  } accMode_e;

  // Strobes from the control pipe to the datapath, aligned with the count.
  typedef struct packed {
    logic accEn;
    logic negate;
    logic zeroSel;
    logic shiftSel;
  } dpuStrb_t;

  function automatic int treeLevels(input int vecW);
    return $clog2((vecW + 2) / 3);
  endfunction

endpackage

// File: rtl/bitserial_dpu_ctrl.sv
module bitserial_dpu_ctrl
  import bitserial_dpu_pkg::*;
#(
  parameter int PIPE_D = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       negate,
  input  logic [1:0] accMode,
  output dpuStrb_t   strbO
);

  typedef struct packed {
    logic vld;
    logic neg;
    logic [1:0] mode;
  } slot_t;

  slot_t pipeQ [PIPE_D];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < PIPE_D; s++) pipeQ[s] <= '0;
    end else begin
      pipeQ[0] <= '{vld: inValid, neg: negate, mode: accMode};
      for (int s = 1; s < PIPE_D; s++) pipeQ[s] <= pipeQ[s-1];
    end
  end

  always_comb begin
    strbO.accEn    = pipeQ[PIPE_D-1].vld;
    strbO.negate   = pipeQ[PIPE_D-1].neg;
    strbO.zeroSel  = pipeQ[PIPE_D-1].mode == ACC_ZERO;
    strbO.shiftSel = pipeQ[PIPE_D-1].mode == ACC_DOUBLE;
  end

  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rstN) $onehot0({strbO.zeroSel, strbO.shiftSel})); // R3

endmodule

// File: rtl/bitserial_dpu_datapath.sv
module bitserial_dpu_datapath
  import bitserial_dpu_pkg::*;
#(
  parameter int VEC_W = 32,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [VEC_W-1:0] lhsBits,
  input  logic [VEC_W-1:0] rhsBits,
  input  dpuStrb_t         strb,
  output logic             outValid,
  output logic [ACC_W-1:0] accOut
);

  localparam int NGRP  = (VEC_W + 2) / 3;
  localparam int LVLS  = treeLevels(VEC_W);
  localparam int NPAD  = 1 << LVLS;
  localparam int NODES = 2 * NPAD - 1;
  localparam int CNT_W = $clog2(VEC_W + 1);
  localparam int PAD_W = 3 * NPAD;

  function automatic int levelBase(input int lvl);
    return 2 * NPAD - ((2 * NPAD) >> lvl);
  endfunction

  // Fused AND and 3:2 pre-compression, one full adder per group of three.
  logic [PAD_W-1:0] prodBits;
  logic [1:0]       preCnt [NPAD];

  assign prodBits = PAD_W'(lhsBits & rhsBits);

  for (genvar g = 0; g < NPAD; g++) begin : gGrp
    logic x, y, z;
    assign x = prodBits[3*g];
    assign y = prodBits[3*g+1];
    assign z = prodBits[3*g+2];
    assign preCnt[g] = {(x & y) | (x & z) | (y & z), x ^ y ^ z};
  end

  // Registered reduction tree; level 0 holds the group counts.
  logic [CNT_W-1:0] nodeQ [NODES];
  logic [CNT_W-1:0] nodeD [NODES];

  always_comb begin
    for (int g = 0; g < NPAD; g++) nodeD[g] = CNT_W'(preCnt[g]);
    for (int l = 1; l <= LVLS; l++) begin
      for (int n = 0; n < (NPAD >> l); n++) begin
        nodeD[levelBase(l) + n] = nodeQ[levelBase(l-1) + 2*n]
                                + nodeQ[levelBase(l-1) + 2*n + 1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int n = 0; n < NODES; n++) nodeQ[n] <= '0;
    end else begin
      nodeQ <= nodeD;
    end
  end

  // Accumulate: base is zero, old value, or old value doubled.
  logic [CNT_W-1:0] popCnt;
  logic [ACC_W-1:0] popExt, contrib, baseVal, accQ;
  logic             validQ;

  assign popCnt  = nodeQ[NODES-1];
  assign popExt  = ACC_W'(popCnt);
  assign contrib = strb.negate ? (~popExt + 1'b1) : popExt;
  assign baseVal = strb.zeroSel  ? '0 :
                   strb.shiftSel ? {accQ[ACC_W-2:0], 1'b0} : accQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ   <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= strb.accEn;
      if (strb.accEn) accQ <= baseVal + contrib;
    end
  end

  assign outValid = validQ;
  assign accOut   = accQ;

  AST_POP_RANGE: assert property (@(posedge clk) disable iff (!rstN) popExt <= ACC_W'(VEC_W)); // R2
  AST_ZERO_START: assert property (@(posedge clk) disable iff (!rstN) strb.accEn && strb.zeroSel && !strb.negate |=> accQ == $past(popExt)); // R4
  AST_NEG_START: assert property (@(posedge clk) disable iff (!rstN) strb.accEn && strb.zeroSel && strb.negate |=> accQ + $past(popExt) == '0); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN) !strb.accEn |=> $stable(accQ) && !outValid); // R6
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rstN) strb.accEn && strb.shiftSel && !strb.negate |=> accQ == ($past(accQ) << 1) + $past(popExt)); // R7

endmodule

// File: rtl/bitserial_dpu.sv
module bitserial_dpu
  import bitserial_dpu_pkg::*;
#(
  parameter int VEC_W = 32,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [VEC_W-1:0] lhsBits,
  input  logic [VEC_W-1:0] rhsBits,
  input  logic             negate,
  input  logic [1:0]       accMode,
  output logic             outValid,
  output logic [ACC_W-1:0] accOut
);

  localparam int PIPE_D = treeLevels(VEC_W) + 1;

  dpuStrb_t strb;

  bitserial_dpu_ctrl #(.PIPE_D(PIPE_D)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .negate  (negate),
    .accMode (accMode),
    .strbO   (strb)
  );

  bitserial_dpu_datapath #(.VEC_W(VEC_W), .ACC_W(ACC_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .lhsBits  (lhsBits),
    .rhsBits  (rhsBits),
    .strb     (strb),
    .outValid (outValid),
    .accOut   (accOut)
  );

endmodule

// File: tb/bitserial_dpu_tb_top.sv
`timescale 1ns/1ps
module bitserial_dpu_tb_top;
  localparam int K = 32;
  localparam int AW = 32;
  localparam int EXP_LAT = $clog2((K + 2) / 3) + 2;

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0, negate = 1'b0;
  logic [1:0] accMode = 2'b00;
  logic [K-1:0] lhsBits = '0, rhsBits = '0;
  logic outValid;
  logic [AW-1:0] accOut;

  always #10 clk = ~clk;

  bitserial_dpu #(.VEC_W(K), .ACC_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .lhsBits(lhsBits), .rhsBits(rhsBits),
    .negate(negate), .accMode(accMode), .outValid(outValid), .accOut(accOut)
  );

  int checks = 0, failures = 0, modelAcc = 0;
  int expQ[$];
  string tagQ[$];

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  function automatic logic [K-1:0] ones(int n);
    return K'((64'd1 << n) - 1);
  endfunction

  task automatic issue(logic [K-1:0] l, logic [K-1:0] r, bit neg, logic [1:0] md, string tag);
    int c = $countones(l & r);
    int base;
    case (md)
      2'b01:   base = 0;
      2'b10:   base = modelAcc * 2;
      default: base = modelAcc;
    endcase
    modelAcc = base + (neg ? -c : c);
    expQ.push_back(modelAcc);
    tagQ.push_back(tag);
    lhsBits = l; rhsBits = r; negate = neg; accMode = md; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; lhsBits = '0; rhsBits = '0; negate = 1'b0; accMode = 2'b00;
  endtask

  task automatic drain();
    repeat (EXP_LAT + 2) @(negedge clk);
    check(expQ.size() == 0, "R8 every slice answered", expQ.size(), 0);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected outValid", int'(accOut), 0);
      end else begin
        int e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check($signed(accOut) == e, t, $signed(accOut), e);
      end
    end
  end

  task automatic dotRun(int pa, int pb, bit sgn, string tag);
    int a[2*K];
    int b[2*K];
    longint dot = 0;
    bit first = 1'b1;
    for (int m = 0; m < 2*K; m++) begin
      a[m] = int'($urandom_range(0, (1 << pa) - 1));
      b[m] = int'($urandom_range(0, (1 << pb) - 1));
      if (sgn) begin
        a[m] -= (1 << (pa - 1));
        b[m] -= (1 << (pb - 1));
      end
      dot += longint'(a[m]) * longint'(b[m]);
    end
    for (int s = pa + pb - 2; s >= 0; s--) begin
      bit newWave = 1'b1;
      for (int i = 0; i < pa; i++) begin
        int j = s - i;
        if (j < 0 || j >= pb) continue;
        for (int c = 0; c < 2; c++) begin
          logic [K-1:0] l, r;
          logic [1:0] md;
          bit neg;
          for (int m = 0; m < K; m++) begin
            l[m] = a[c*K + m][i];
            r[m] = b[c*K + m][j];
          end
          md  = first ? 2'b01 : ((newWave && c == 0) ? 2'b10 : 2'b00);
          neg = sgn && ((i == pa - 1) != (j == pb - 1));
          issue(l, r, neg, md, {tag, " step"});
          first = 1'b0;
          newWave = 1'b0;
        end
      end
    end
    expQ[expQ.size() - 1] = int'(dot);
    tagQ[tagQ.size() - 1] = {tag, " final dot product"};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(accOut == '0 && outValid == 1'b0, "R1 state during reset", int'(accOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(accOut == '0 && outValid == 1'b0, "R1 state after reset", int'(accOut), 0);

    // R2 / R4: counts under clear mode
    issue('1, '1, 1'b0, 2'b01, "R2 R4 all ones count");
    issue('1, 32'h0000_FFFF, 1'b0, 2'b01, "R2 R4 half count");
    issue(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 2'b01, "R2 R4 disjoint count");
    issue(32'h8000_0000, '1, 1'b0, 2'b01, "R2 top partial group");
    issue(32'hC000_0001, 32'hFFFF_FFFF, 1'b0, 2'b01, "R2 edge groups");
    drain();

    // R8: latency of a single slice
    begin
      int cnt = 1;
      issue(ones(4), '1, 1'b0, 2'b01, "R8 latency item");
      while (!outValid && cnt < 30) begin
        @(negedge clk);
        cnt++;
      end
      check(cnt == EXP_LAT, "R8 latency", cnt, EXP_LAT);
    end
    drain();

    // R7: doubling
    issue(ones(3), '1, 1'b0, 2'b01, "R7 seed");
    issue(ones(2), '1, 1'b0, 2'b10, "R7 double plus two");
    issue('0, '1, 1'b0, 2'b10, "R7 double plus zero");
    // R5: negation in every mode
    issue(ones(7), '1, 1'b1, 2'b01, "R5 negate clear");
    issue(ones(2), '1, 1'b1, 2'b00, "R5 negate keep");
    issue(ones(1), '1, 1'b1, 2'b10, "R5 R7 negate double");
    // R3: reserved code keeps
    issue(ones(5), '1, 1'b0, 2'b01, "R3 seed");
    issue(ones(3), '1, 1'b0, 2'b11, "R3 reserved code keeps");
    issue(ones(1), '1, 1'b0, 2'b00, "R3 keep code");
    drain();

    // R6: junk on inputs with inValid low
    for (int n = 0; n < 8; n++) begin
      lhsBits = K'($urandom); rhsBits = K'($urandom);
      negate = 1'($urandom); accMode = 2'($urandom);
      @(negedge clk);
      check($signed(accOut) == modelAcc && !outValid, "R6 idle holds", $signed(accOut), modelAcc);
    end
    lhsBits = '0; rhsBits = '0; negate = 1'b0; accMode = 2'b00;

    // R9 / R8: whole dot products streamed back to back
    dotRun(2, 2, 1'b0, "R9 unsigned 2x2");
    dotRun(3, 2, 1'b0, "R9 unsigned 3x2");
    dotRun(3, 3, 1'b1, "R9 R8 signed 3x3");
    dotRun(4, 2, 1'b1, "R9 R8 signed 4x2");
    dotRun(1, 1, 1'b0, "R9 binary 1x1");
    dotRun(4, 4, 1'b1, "R9 signed 4x4");
    dotRun(2, 3, 1'b1, "R9 signed 2x3");
    drain();

    summary();
    $finish;
  end

endmodule